// File: doc/BRIEF.md
# Programmable-Tap LFSR PWM Generator

This block produces a pseudo-random pulse-width-modulated output from a linear feedback shift register of `CNT_WIDTH` bits. The register shifts toward bit 0 on every enabled clock. The bit that enters at the top is the XOR of the register bits that the active tap mask selects. Because the taps are a run-time bitmask and the feedback always enters the most significant bit, a shorter sequence can run in the upper bits of the wider register.

Software-side logic writes a buffered tap mask and a compare value. A switch strobe, applied while the generator is enabled, moves the buffered mask into the active mask. The output is high while the current register state is below the compare value. This gives a pseudo-random duty cycle set by the compare value. A register state of all zeros is never allowed to persist: it is replaced by all ones.

Top module: `lfsr_pwm`

## Requirements
- R1: A synchronous active-high reset sets the state to all ones, the buffered mask to all ones, the active mask to zero and the compare value to zero, so `pwm_o` is low.
- R2: On each clock with `en` high, the new state is {f, old state[CNT_WIDTH-1:1]}, where f is the XOR of every old state bit whose active-mask bit is 1.
- R3: With `en` low, the state and the active mask hold, and `swap` has no effect.
- R4: `swap` with `en` high copies the buffered mask into the active mask. The value copied is the one held before that edge. A write in the same cycle goes to the buffer only. The new taps apply from the next enabled step.
- R5: Bits of `mask_wdata` at positions `CNT_WIDTH` and above have no effect on the sequence.
- R6: When the computed next state is all zeros, all ones is loaded instead. With an empty mask, the state therefore returns to all ones 16 steps after leaving it.
- R7: `pwm_o` is 1 exactly when `state_o` is below the compare value (unsigned). Both change on the same edge, and a compare write takes effect at that edge.
- R8: With mask 0x002D (taps 0, 2, 3, 5) on a 16-bit register, the state sequence repeats every 65535 enabled steps.
- R9: With mask 0x1D00 (taps 8, 10, 11, 12) on a 16-bit register, the state repeats every 255 enabled steps once the lower byte has filled.
- R10: A `mask_wr` write without a later enabled `swap` does not change the taps in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the register this cycle |
| mask_wr | input | 1 | Write `mask_wdata` into the buffered mask |
| mask_wdata | input | MASK_W | Buffered tap mask data |
| cmp_wr | input | 1 | Write `cmp_wdata` into the compare register |
| cmp_wdata | input | CNT_WIDTH | Compare value |
| swap | input | 1 | Switch strobe: copy buffered mask to active mask when `en` is high |
| state_o | output | CNT_WIDTH | Current register state |
| pwm_o | output | 1 | High while state is below compare value |

## Verification
The assertions assume that `rst` is high at the first clock edge and that every input is a known 0 or 1 at each edge. They also assume that `swap` is only meaningful together with `en`. The stimulus keeps to these assumptions in three ways: it starts every run under reset, it drives all inputs on the falling edge from one task, and it returns every control to zero between operations. The one exception is the deliberate tests of `swap` with `en` low. The bench model carries the full write-width buffer, so upper mask bits reach the design unfiltered.

// File: rtl/lfsr_pwm_pkg.sv
package lfsr_pwm_pkg;
  localparam int unsigned MAX_W = 64;
  typedef logic [MAX_W-1:0] word_t;

  // XOR of the state bits selected by the tap mask
  function automatic logic tap_parity(input word_t st, input word_t taps);
    return ^(st & taps);
  endfunction
endpackage

// File: rtl/tap_mask_regs.sv
module tap_mask_regs #(
  parameter int unsigned CNT_WIDTH = 16,
  parameter int unsigned MASK_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 swap,
  input  logic                 mask_wr,
  input  logic [MASK_W-1:0]    mask_wdata,
  output logic [CNT_WIDTH-1:0] act_o
);
  logic [MASK_W-1:0]    buf_q;
  logic [CNT_WIDTH-1:0] buf_low;
  logic [CNT_WIDTH-1:0] act_q;

  generate
    if (MASK_W >= CNT_WIDTH) begin : g_slice
      assign buf_low = buf_q[CNT_WIDTH-1:0];
    end else begin : g_pad
      assign buf_low = {{(CNT_WIDTH-MASK_W){1'b0}}, buf_q};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '1;
      act_q <= '0;
    end else begin
      if (mask_wr) buf_q <= mask_wdata;
      if (swap && en) act_q <= buf_low;
    end
  end

  assign act_o = act_q;

  // R1
  mask_rst_chk: assert property (@(posedge clk)
    rst |=> (buf_q == '1 && act_q == '0));
  // R4
  mask_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (swap && en) |=> act_q == $past(buf_low));
  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(swap && en) |=> $stable(act_q));
endmodule

// File: rtl/lfsr_core.sv
module lfsr_core #(
  parameter int unsigned CNT_WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [CNT_WIDTH-1:0] taps,
  output logic [CNT_WIDTH-1:0] state_o,
  output logic [CNT_WIDTH-1:0] state_d_o
);
  import lfsr_pwm_pkg::*;

  logic [CNT_WIDTH-1:0] state_q;
  logic [CNT_WIDTH-1:0] shifted;
  logic                 fb;

  always_comb begin
    fb      = tap_parity(word_t'(state_q), word_t'(taps));
    shifted = {fb, state_q[CNT_WIDTH-1:1]};
    if (!en)
      state_d_o = state_q;
    else if (shifted == '0)
      state_d_o = '1;
    else
      state_d_o = shifted;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= '1;
    else     state_q <= state_d_o;
  end

  assign state_o = state_q;

  // R6
  state_nz_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
  // R3
  state_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state_q));
  // R2
  state_shift_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (state_q[CNT_WIDTH-2:0] == $past(state_q[CNT_WIDTH-1:1])) || (state_q == '1));
  // R2
  state_fb_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (state_q[CNT_WIDTH-1] == ^($past(state_q & taps))) || (state_q == '1));
endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp #(
  parameter int unsigned CNT_WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmp_wr,
  input  logic [CNT_WIDTH-1:0] cmp_wdata,
  input  logic [CNT_WIDTH-1:0] state_d_i,
  input  logic [CNT_WIDTH-1:0] state_q_i,
  output logic                 pwm_o
);
  logic [CNT_WIDTH-1:0] cmp_q;
  logic [CNT_WIDTH-1:0] cmp_d;
  logic                 pwm_q;

  assign cmp_d = cmp_wr ? cmp_wdata : cmp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      pwm_q <= (state_d_i < cmp_d);
    end
  end

  assign pwm_o = pwm_q;

  // R7
  pwm_match_chk: assert property (@(posedge clk) disable iff (rst)
    pwm_q == (state_q_i < cmp_q));
endmodule

// File: rtl/lfsr_pwm.sv
module lfsr_pwm #(
  parameter int unsigned CNT_WIDTH = 16,
  parameter int unsigned MASK_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 mask_wr,
  input  logic [MASK_W-1:0]    mask_wdata,
  input  logic                 cmp_wr,
  input  logic [CNT_WIDTH-1:0] cmp_wdata,
  input  logic                 swap,
  output logic [CNT_WIDTH-1:0] state_o,
  output logic                 pwm_o
);
  logic [CNT_WIDTH-1:0] act_taps;
  logic [CNT_WIDTH-1:0] state_q;
  logic [CNT_WIDTH-1:0] state_d;

  tap_mask_regs #(.CNT_WIDTH(CNT_WIDTH), .MASK_W(MASK_W)) masks_i (
    .clk(clk), .rst(rst), .en(en), .swap(swap),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .act_o(act_taps)
  );

  lfsr_core #(.CNT_WIDTH(CNT_WIDTH)) core_i (
    .clk(clk), .rst(rst), .en(en), .taps(act_taps),
    .state_o(state_q), .state_d_o(state_d)
  );

  pwm_cmp #(.CNT_WIDTH(CNT_WIDTH)) cmp_i (
    .clk(clk), .rst(rst), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .state_d_i(state_d), .state_q_i(state_q), .pwm_o(pwm_o)
  );

  assign state_o = state_q;
endmodule

// File: tb/lfsr_pwm_tb_top.sv
module lfsr_pwm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int MW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0, mask_wr = 1'b0, cmp_wr = 1'b0, swap = 1'b0;
  logic [MW-1:0] mask_wdata = '0;
  logic [W-1:0]  cmp_wdata = '0;
  logic [W-1:0]  state_o;
  logic          pwm_o;

  lfsr_pwm #(.CNT_WIDTH(W), .MASK_W(MW)) dut_i (
    .clk(clk), .rst(rst), .en(en), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .swap(swap),
    .state_o(state_o), .pwm_o(pwm_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model state
  logic [W-1:0]  m_st, m_act, m_cmp;
  logic [MW-1:0] m_buf;
  int tests = 0;
  int fails = 0;

  // {mask[31:0], cmp[15:0], steps[15:0]}
  localparam logic [63:0] VEC [6] = '{
    {32'h0000_002D, 16'h8000, 16'd40},
    {32'h0000_1D00, 16'h4000, 16'd40},
    {32'hFFFF_002D, 16'h1234, 16'd30},
    {32'h0000_A5A5, 16'hFFFF, 16'd30},
    {32'h0000_0001, 16'h0100, 16'd30},
    {32'h0000_0000, 16'h0002, 16'd40}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0; swap = 1'b0; mask_wr = 1'b0; cmp_wr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_st = '1; m_act = '0; m_buf = '1; m_cmp = '0;
  endtask

  task automatic cyc(input logic e, input logic sw, input logic mw, input logic [MW-1:0] md,
                     input logic cw, input logic [W-1:0] cd, input logic do_chk, input string tag);
    logic [W-1:0] nxt;
    @(negedge clk);
    en = e; swap = sw; mask_wr = mw; mask_wdata = md; cmp_wr = cw; cmp_wdata = cd;
    @(posedge clk);
    if (e) begin
      nxt = {^(m_st & m_act), m_st[W-1:1]};
      if (nxt == '0) nxt = '1;
      m_st = nxt;
      if (sw) m_act = m_buf[W-1:0];
    end
    if (mw) m_buf = md;
    if (cw) m_cmp = cd;
    #1;
    if (do_chk) begin
      check({tag, " state"}, 32'(state_o), 32'(m_st));
      check({tag, " pwm"}, 32'(pwm_o), 32'(m_st < m_cmp));
    end
  endtask

  task automatic idle();
    @(negedge clk);
    en = 1'b0; swap = 1'b0; mask_wr = 1'b0; cmp_wr = 1'b0;
  endtask

  task automatic measure(input logic [MW-1:0] mask, input int warm, input int limit, output int n);
    logic [W-1:0] s0;
    do_reset();
    cyc(1'b0, 1'b0, 1'b1, mask, 1'b0, '0, 1'b0, "");
    cyc(1'b1, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0, "");
    for (int i = 0; i < warm; i++) cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, "");
    s0 = state_o;
    n = 0;
    do begin
      cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, "");
      n++;
    end while (state_o != s0 && n < limit);
    idle();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int n;
    logic [W-1:0] s;
    // R1: reset values
    do_reset();
    #1;
    check("R1 reset state", 32'(state_o), 32'hFFFF);
    check("R1 reset pwm", 32'(pwm_o), 32'h0);
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, '0, 1'b1, "R1 active mask zero");
    cyc(1'b1, 1'b1, 1'b0, '0, 1'b0, '0, 1'b1, "R1 buffer ones");
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, '0, 1'b1, "R1 buffer ones");

    // R2, R5, R6, R7: vector table walk
    foreach (VEC[k]) begin
      do_reset();
      cyc(1'b0, 1'b0, 1'b1, VEC[k][63:32], 1'b1, VEC[k][31:16], 1'b1, "R7 load");
      cyc(1'b1, 1'b1, 1'b0, '0, 1'b0, '0, 1'b1, "R4 swap");
      for (int i = 0; i < int'(VEC[k][15:0]); i++)
        cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, '0, 1'b1, "R2 R5 R6 R7 vector");
    end

    // R3: enable low holds state, swap ignored
    do_reset();
    cyc(1'b0, 1'b0, 1'b1, 32'h2D, 1'b0, '0, 1'b0, "");
    cyc(1'b1, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0, "");
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, "");
    s = state_o;
    cyc(1'b0, 1'b0, 1'b1, 32'h1D00, 1'b0, '0, 1'b1, "R3 hold");
    cyc(1'b0, 1'b1, 1'b0, '0, 1'b0, '0, 1'b1, "R3 swap ignored");
    check("R3 held value", 32'(state_o), 32'(s));
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, '0, 1'b1, "R3 old taps kept");

    // R10: write without swap keeps taps; R4: write and swap in the same cycle
    cyc(1'b1, 1'b0, 1'b1, 32'hA5A5, 1'b0, '0, 1'b1, "R10 write only");
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, '0, 1'b1, "R10 taps unchanged");
    cyc(1'b1, 1'b1, 1'b1, 32'h0001, 1'b0, '0, 1'b1, "R4 same-cycle write");
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, '0, 1'b1, "R4 old buffer used");
    cyc(1'b1, 1'b1, 1'b0, '0, 1'b0, '0, 1'b1, "R4 second swap");
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, '0, 1'b1, "R4 new buffer used");

    // R7: compare boundary
    s = state_o;
    cyc(1'b0, 1'b0, 1'b0, '0, 1'b1, s, 1'b1, "R7 equal");
    check("R7 equal is low", 32'(pwm_o), 32'h0);
    if (s != 16'hFFFF) begin
      cyc(1'b0, 1'b0, 1'b0, '0, 1'b1, s + 16'd1, 1'b1, "R7 one above");
      check("R7 one above is high", 32'(pwm_o), 32'h1);
    end
    cyc(1'b0, 1'b0, 1'b0, '0, 1'b1, 16'h0000, 1'b1, "R7 zero compare");
    check("R7 zero compare low", 32'(pwm_o), 32'h0);

    // R6: empty mask returns to all ones after 16 steps
    measure(32'h0, 0, 100, n);
    check("R6 reseed cycle", 32'(n), 32'd16);
    // R8: maximal 16-bit sequence
    measure(32'h002D, 10, 70000, n);
    check("R8 period", 32'(n), 32'd65535);
    // R9: 8-bit sequence in the upper byte
    measure(32'h1D00, 300, 1000, n);
    check("R9 period", 32'(n), 32'd255);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule